// File: doc/BRIEF.md
# Supply Channel Power-Up Sequencer with Fault Retry

This block is the control state machine for up to three switched supply channels. It decides when each channel's pass switch is commanded on, whether the channels rise together behind one common reference ramp (tracking) or one after another (sequencing), and how the system recovers from a failed power-up. Analog gate drive, ramp generation and threshold comparison sit outside. The block sees only their results as per-channel flags: input above its undervoltage limit, output at power-good level, and output below the power-low level. It also receives a tracking-error flag from the ramp comparators.

All timing comes from one prescaled tick. A start delay, a power-up deadline and a retry wait are counted in ticks, and the retry wait is fixed at sixteen deadlines. After a fault the block either retries on its own or stays latched until the enable input is cycled. Every pin is a plain level or control signal. The block moves no data, so it has no valid/ready stream interface and applies no back-pressure.

A tick lasts `PRESCALE` clock cycles. A timed phase programmed for N ticks holds its outputs for N*`PRESCALE`+1 cycles, because one extra cycle is spent on the state change. Bit i of every per-channel vector belongs to channel i+1.

Top module: `pwrseq_ctrl`

## Requirements
- R1: Power-up starts from idle only when `en_i` is 1, every `uv_ok_i` bit is 1, and `plow_i` is 1 for every channel that is not excluded. Until then all outputs keep their idle values.
- R2: Tracking mode (`seq_mode_i`=0): after one start delay of `delay_ticks_i` ticks, every non-excluded channel is turned on at the same time, with `ramp_en_o`=1 and `ramp_up_o`=1.
- R3: Sequencing mode (`seq_mode_i`=1): channels come up in the order channel 1, channel 2, channel 3, and a start delay comes before each of them. Each channel's delay begins only after the previous channel reports power-good. Channels already up stay on during the delays, which show `ramp_en_o`=0.
- R4: Once power-up is complete (every needed power-good flag set), every non-excluded channel is on, the ramp is idle, and no discharge is active.
- R5: A fault is any of the following: the deadline of `deadline_ticks_i` ticks runs out before a power-up phase completes, or `trk_fault_i` is seen during the ramp-up or the ramp-down. On a fault all channels turn off together, all `dischg_o` bits go to 1, and `fault_n_o` goes to 0.
- R6: In retry mode (`latch_mode_i`=0) a fault holds the discharge for exactly 16 deadlines, then for one start delay, and then returns to idle with `fault_n_o`=1. A new power-up then follows only under the R1 conditions, so every needed output must read power-low.
- R7: In latch mode (`latch_mode_i`=1) a fault holds for as long as `en_i` stays high. After `en_i` goes low and then high again, the block waits one retry period (16 deadlines) and then returns to idle.
- R8: When `en_i` falls after power-up is complete, in either mode, all non-excluded channels stay on while the ramp runs down (`ramp_en_o`=1, `ramp_up_o`=0). Idle is reached only when every needed `plow_i` bit is 1.
- R9: If `en_i` or any `uv_ok_i` bit drops during the start delay or the ramp-up, the block does not ramp down. It makes a fast shutdown instead: all channels off, all discharges on, `fault_n_o` left at 1. It returns to idle once every needed output reads power-low.
- R10: A channel with `excl_i` set is skipped in the sequence, is never turned on, and its power-good and power-low flags are ignored.
- R11: Reset leaves all channels off, the ramp idle, no discharge and `fault_n_o`=1. Discharge is never active while any channel is commanded on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | System enable level |
| uv_ok_i | input | NCH | Input supply above its undervoltage limit, per channel |
| pgood_i | input | NCH | Output at power-good level, per channel |
| plow_i | input | NCH | Output below power-low level (discharged), per channel |
| excl_i | input | NCH | Channel excluded from control |
| trk_fault_i | input | 1 | Tracking error beyond the fault window |
| seq_mode_i | input | 1 | 1 selects sequencing, 0 selects tracking |
| latch_mode_i | input | 1 | 1 selects latch-off, 0 selects auto-retry |
| delay_ticks_i | input | TW | Start delay in ticks |
| deadline_ticks_i | input | TW | Power-up deadline in ticks |
| chan_on_o | output | NCH | Turn-on command per channel |
| ramp_en_o | output | 1 | Reference ramp running |
| ramp_up_o | output | 1 | Ramp direction, 1 is upward |
| dischg_o | output | NCH | Fast discharge enable per channel |
| fault_n_o | output | 1 | Fault indication, active low |

## Verification
The bench goes after the moments where a wrong design would still look plausible. If the retry wait were not tied to sixteen deadlines, the return to idle would land well outside the expected cycle. If the machine restarted without waiting for power-low, it would turn channels on while one output still reads high. A latch that released without an enable cycle would produce output changes during a long hold with enable kept high. The bench also drops enable or an undervoltage flag during ramp-up: a design that ramps down there, instead of discharging, shows the wrong output vector. In sequencing, it checks that an excluded channel is skipped and that the next delay waits for power-good.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  // Retry period is the power-up deadline shifted by this amount (x16).
  localparam int RETRY_SHIFT = 4;

  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for start conditions
    ST_DLY,    // start delay (before ramp or before next channel)
    ST_UP,     // ramp-up phase under deadline
    ST_ON,     // power-up complete
    ST_DN,     // controlled ramp-down
    ST_SHUT,   // fast shutdown after aborted power-up
    ST_FWAIT,  // retry mode: discharge for retry period
    ST_FDLY,   // retry mode: one delay before idle
    ST_LATCH,  // latch mode: hold while enable high
    ST_LLOW,   // latch mode: enable seen low
    ST_LRTY    // latch mode: retry period after enable returns
  } pseq_state_e;

endpackage

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
  parameter int PRESCALE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (restart_i || tick_o)
      pre_q <= '0;
    else
      pre_q <= pre_q + 1'b1;
  end

  generate
    if (PRESCALE > 1) begin : g_spaced
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2
    end
  endgenerate

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (tick_i && !expired_o)
      cnt_q <= cnt_q - 1'b1;
  end

  AST_TIMER_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cnt_q <= $past(cnt_q))); // R6

endmodule

// File: rtl/pwrseq_pick.sv
module pwrseq_pick #(
  parameter int NCH = 3,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] excl_i,
  input  logic [IW-1:0]  cur_i,
  output logic [IW-1:0]  first_o,
  output logic [IW-1:0]  next_o,
  output logic           has_next_o,
  output logic [NCH-1:0] upto_o,
  output logic [NCH-1:0] below_o
);
  // Masks of channels at or before / strictly before the current one.
  for (genvar g = 0; g < NCH; g++) begin : g_mask
    assign upto_o[g]  = (int'(cur_i) >= g);
    assign below_o[g] = (int'(cur_i) > g);
  end

  // Lowest-numbered included channel overall and after the current one.
  always_comb begin
    first_o    = '0;
    next_o     = cur_i;
    has_next_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (!excl_i[i]) begin
        first_o = IW'(i);
        if (i > int'(cur_i)) begin
          next_o     = IW'(i);
          has_next_o = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int TW       = 16,
  parameter int PRESCALE = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [NCH-1:0] uv_ok_i,
  input  logic [NCH-1:0] pgood_i,
  input  logic [NCH-1:0] plow_i,
  input  logic [NCH-1:0] excl_i,
  input  logic           trk_fault_i,
  input  logic           seq_mode_i,
  input  logic           latch_mode_i,
  input  logic [TW-1:0]  delay_ticks_i,
  input  logic [TW-1:0]  deadline_ticks_i,
  output logic [NCH-1:0] chan_on_o,
  output logic           ramp_en_o,
  output logic           ramp_up_o,
  output logic [NCH-1:0] dischg_o,
  output logic           fault_n_o
);
  localparam int CW = TW + RETRY_SHIFT;
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  pseq_state_e   st_q, st_d;
  logic [IW-1:0] cur_q, cur_d;
  logic          load;
  logic [CW-1:0] load_val;
  logic          tick;
  logic          expired;
  logic [IW-1:0] first_ch, next_ch;
  logic          has_next;
  logic [NCH-1:0] upto_m, below_m, need_m;
  logic          start_ok, all_low, all_good, up_done, abort, fault_st;

  // ---------------- timebase ----------------
  pwrseq_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (load),
    .tick_o    (tick)
  );

  pwrseq_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .expired_o  (expired)
  );

  pwrseq_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .excl_i     (excl_i),
    .cur_i      (cur_q),
    .first_o    (first_ch),
    .next_o     (next_ch),
    .has_next_o (has_next),
    .upto_o     (upto_m),
    .below_o    (below_m)
  );

  // ---------------- condition decode ----------------
  assign need_m   = ~excl_i;
  assign all_low  = &(plow_i | excl_i);
  assign all_good = &(pgood_i | excl_i);
  assign start_ok = en_i && (&uv_ok_i) && all_low;
  assign abort    = !en_i || !(&uv_ok_i);
  assign up_done  = seq_mode_i ? (pgood_i[cur_q] || excl_i[cur_q]) : all_good;
  assign fault_st = (st_q == ST_FWAIT) || (st_q == ST_FDLY) || (st_q == ST_LATCH) ||
                    (st_q == ST_LLOW)  || (st_q == ST_LRTY);

  // ---------------- next state ----------------
  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    unique case (st_q)
      ST_IDLE: if (start_ok) begin
        st_d  = ST_DLY;
        cur_d = first_ch;
      end
      ST_DLY: begin
        if (abort)        st_d = ST_SHUT;
        else if (expired) st_d = ST_UP;
      end
      ST_UP: begin
        if (abort)
          st_d = ST_SHUT;
        else if (trk_fault_i)
          st_d = latch_mode_i ? ST_LATCH : ST_FWAIT;
        else if (up_done) begin
          if (seq_mode_i && has_next) begin
            st_d  = ST_DLY;
            cur_d = next_ch;
          end else begin
            st_d = ST_ON;
          end
        end else if (expired)
          st_d = latch_mode_i ? ST_LATCH : ST_FWAIT;
      end
      ST_ON:    if (abort) st_d = ST_DN;
      ST_DN: begin
        if (trk_fault_i)  st_d = latch_mode_i ? ST_LATCH : ST_FWAIT;
        else if (all_low) st_d = ST_IDLE;
      end
      ST_SHUT:  if (all_low) st_d = ST_IDLE;
      ST_FWAIT: if (expired) st_d = ST_FDLY;
      ST_FDLY:  if (expired) st_d = ST_IDLE;
      ST_LATCH: if (!en_i) st_d = ST_LLOW;
      ST_LLOW:  if (en_i) st_d = ST_LRTY;
      ST_LRTY: begin
        if (!en_i)        st_d = ST_LLOW;
        else if (expired) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Timer reload on every state change, value chosen by the state entered.
  assign load = (st_d != st_q);

  always_comb begin
    unique case (st_d)
      ST_DLY, ST_FDLY:  load_val = CW'(delay_ticks_i);
      ST_UP:            load_val = CW'(deadline_ticks_i);
      ST_FWAIT, ST_LRTY: load_val = CW'(deadline_ticks_i) << RETRY_SHIFT;
      default:          load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    chan_on_o = '0;
    unique case (st_q)
      ST_DLY:       chan_on_o = seq_mode_i ? (below_m & need_m) : '0;
      ST_UP:        chan_on_o = seq_mode_i ? (upto_m & need_m) : need_m;
      ST_ON, ST_DN: chan_on_o = need_m;
      default:      chan_on_o = '0;
    endcase
  end

  assign ramp_en_o = (st_q == ST_UP) || (st_q == ST_DN);
  assign ramp_up_o = (st_q == ST_UP);
  assign dischg_o  = (fault_st || (st_q == ST_SHUT)) ? '1 : '0;
  assign fault_n_o = !fault_st;

  // ---------------- assertions ----------------
  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && !start_ok |=> (st_q == ST_IDLE)); // R1

  AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    seq_mode_i && $rose(chan_on_o[NCH-1]) |-> (chan_on_o[0] || excl_i[0])); // R3

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> (chan_on_o == '0) && (&dischg_o)); // R5

  AST_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UP) && expired && !up_done && en_i && (&uv_ok_i) |=> !fault_n_o); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LATCH) && en_i |=> (st_q == ST_LATCH)); // R7

  AST_DN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en_o && !ramp_up_o |-> (chan_on_o == ~excl_i)); // R8

  AST_ABORT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DLY) || (st_q == ST_UP)) && !en_i |=> (st_q == ST_SHUT)); // R9

  AST_EXCL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on_o & excl_i) == '0); // R10

  AST_NO_DISCHG_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on_o != '0) |-> (dischg_o == '0)); // R11

endmodule

// File: tb/pwrseq_ctrl_tb_top.sv
module pwrseq_ctrl_tb_top;
  localparam int NCH  = 3;
  localparam int TW   = 8;
  localparam int PRE  = 2;
  localparam int DLYT = 3;
  localparam int FDLT = 4;
  localparam int DLYC = DLYT * PRE + 1;
  localparam int FDLC = FDLT * PRE + 1;
  localparam int RTYC = FDLT * 16 * PRE + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, trk = 1'b0, seqm = 1'b0, latm = 1'b0;
  logic [NCH-1:0] uv = '1, pgood = '0, plow = '1, excl = '0;
  logic [NCH-1:0] chan_on, dischg;
  logic ramp_en, ramp_up, fault_n;

  always #10 clk = ~clk;

  pwrseq_ctrl #(.NCH(NCH), .TW(TW), .PRESCALE(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uv_ok_i(uv), .pgood_i(pgood),
    .plow_i(plow), .excl_i(excl), .trk_fault_i(trk), .seq_mode_i(seqm),
    .latch_mode_i(latm), .delay_ticks_i(TW'(DLYT)), .deadline_ticks_i(TW'(FDLT)),
    .chan_on_o(chan_on), .ramp_en_o(ramp_en), .ramp_up_o(ramp_up),
    .dischg_o(dischg), .fault_n_o(fault_n)
  );

  wire [8:0] outv = {fault_n, ramp_en, ramp_up, dischg, chan_on};

  function automatic logic [8:0] vup(input logic [2:0] m);  return {3'b111, 3'b000, m}; endfunction
  function automatic logic [8:0] von(input logic [2:0] m);  return {3'b100, 3'b000, m}; endfunction
  function automatic logic [8:0] vdn(input logic [2:0] m);  return {3'b110, 3'b000, m}; endfunction
  localparam logic [8:0] VIDLE = 9'b100_000_000;
  localparam logic [8:0] VFLT  = 9'b000_111_000;
  localparam logic [8:0] VSHUT = 9'b100_111_000;

  typedef struct {
    logic [8:0] v;
    int         t;
    string      r;
  } ev_t;

  ev_t   evq[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  logic  mon_on = 1'b0;
  logic [8:0] prev;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every output change pops one expected event and compares.
  always @(negedge clk) begin
    ev_t e;
    if (mon_on && outv !== prev) begin
      checks++;
      if (evq.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected change at cycle %0d, actual %b expected %b", cur_req, cyc, outv, prev);
      end else begin
        e = evq.pop_front();
        if (outv !== e.v || cyc < e.t - 2 || cyc > e.t + 2) begin
          errors++;
          $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d", e.r, outv, cyc, e.v, e.t);
        end
      end
      prev = outv;
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual cycle %0d, expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic exp(input logic [8:0] v, input int t, input string r);
    ev_t e;
    e.v = v; e.t = t; e.r = r;
    evq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string r);
    step(4);
    checks++;
    if (evq.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d events never seen, expected 0", r, evq.size());
      evq.delete();
    end
  endtask

  // Start from idle; power-up ramp expected one delay later.
  task automatic start(input logic [2:0] m, input string r);
    en = 1'b1;
    exp(vup(m), cyc + 1 + DLYC, r);
  endtask

  task automatic bring_on(input logic [2:0] pg, input logic [2:0] m);
    pgood = pg;
    plow  = '0;
    exp(von(m), cyc + 1, "R4");
    step(3);
  endtask

  task automatic power_down(input logic [2:0] m);
    cur_req = "R8";
    en = 1'b0;
    exp(vdn(m), cyc + 1, "R8");
    step(3);
    pgood = '0;
    plow  = 3'b011;      // channel 3 still high: ramp-down must hold
    step(6);
    plow = '1;
    exp(VIDLE, cyc + 1, "R8");
    step(3);
    drain("R8");
  endtask

  initial begin
    step(5);
    rst_n = 1'b1;
    step(1);
    checks++;
    if (outv !== VIDLE) begin
      errors++;
      $display("FAIL R11: reset outputs actual %b expected %b", outv, VIDLE);
    end
    prev   = outv;
    mon_on = 1'b1;

    // T1: tracking, normal up and controlled down
    cur_req = "R2";
    start(3'b111, "R2");
    step(DLYC + 3);
    bring_on(3'b111, 3'b111);
    power_down(3'b111);

    // T2: sequencing with channel 2 excluded
    cur_req = "R10";
    seqm = 1'b1; excl = 3'b010;
    step(2);
    start(3'b001, "R3");
    step(DLYC + 3);
    pgood = 3'b001;
    exp(von(3'b001), cyc + 1, "R3");
    exp(vup(3'b101), cyc + 1 + DLYC, "R10");
    step(DLYC + 3);
    bring_on(3'b101, 3'b101);
    power_down(3'b101);

    // T3: sequencing, all three channels in order
    cur_req = "R3";
    excl = '0;
    step(2);
    start(3'b001, "R3");
    step(DLYC + 3);
    pgood = 3'b001;
    exp(von(3'b001), cyc + 1, "R3");
    exp(vup(3'b011), cyc + 1 + DLYC, "R3");
    step(DLYC + 3);
    pgood = 3'b011;
    exp(von(3'b011), cyc + 1, "R3");
    exp(vup(3'b111), cyc + 1 + DLYC, "R3");
    step(DLYC + 3);
    bring_on(3'b111, 3'b111);
    power_down(3'b111);
    seqm = 1'b0;

    // T4: deadline miss, auto-retry timing and restart
    cur_req = "R6";
    step(2);
    begin
      int c;
      c = cyc;
      start(3'b111, "R2");
      exp(VFLT, c + 1 + DLYC + FDLC, "R5");
      exp(VIDLE, c + 1 + DLYC + FDLC + RTYC + DLYC, "R6");
      exp(vup(3'b111), c + 1 + DLYC + FDLC + RTYC + DLYC + 1 + DLYC, "R6");
      step(1 + DLYC + FDLC + RTYC + DLYC + 1 + DLYC + 2);
    end
    bring_on(3'b111, 3'b111);
    power_down(3'b111);

    // T5: tracking fault, retry blocked until outputs discharged
    cur_req = "R1";
    start(3'b111, "R2");
    step(DLYC + 3);
    trk  = 1'b1;
    plow = 3'b011;
    exp(VFLT, cyc + 1, "R5");
    step(1);
    trk = 1'b0;
    exp(VIDLE, cyc + RTYC + DLYC, "R6");
    step(RTYC + DLYC + 15);
    plow = '1;
    exp(vup(3'b111), cyc + 1 + DLYC, "R1");
    step(DLYC + 3);
    bring_on(3'b111, 3'b111);
    power_down(3'b111);

    // T6: latch mode holds until enable cycles
    cur_req = "R7";
    latm = 1'b1;
    step(2);
    start(3'b111, "R2");
    step(DLYC + 3);
    trk = 1'b1;
    exp(VFLT, cyc + 1, "R5");
    step(1);
    trk = 1'b0;
    step(200);
    drain("R7");
    en = 1'b0;
    step(10);
    en = 1'b1;
    exp(VIDLE, cyc + 1 + RTYC, "R7");
    exp(vup(3'b111), cyc + 1 + RTYC + 1 + DLYC, "R7");
    step(RTYC + DLYC + 5);
    bring_on(3'b111, 3'b111);
    power_down(3'b111);
    latm = 1'b0;

    // T7: undervoltage drop during start delay -> fast shutdown
    cur_req = "R9";
    en = 1'b1;
    step(3);
    uv   = 3'b101;
    plow = '0;
    exp(VSHUT, cyc + 1, "R9");
    step(1);
    en = 1'b0;
    step(5);
    plow = '1;
    exp(VIDLE, cyc + 1, "R9");
    step(3);
    uv = '1;
    drain("R9");

    // T8: enable drop during ramp-up -> fast shutdown, not ramp-down
    start(3'b111, "R2");
    step(DLYC + 3);
    en   = 1'b0;
    plow = '0;
    exp(VSHUT, cyc + 1, "R9");
    step(5);
    plow = '1;
    exp(VIDLE, cyc + 1, "R9");
    step(3);
    drain("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule